// File: doc/BRIEF.md
# Multi-Sample Pulse Reconstruction Engine

This block recovers three figures from each short burst of digitized pulse samples belonging to one readout channel. The pulse amplitude (energy) is a weighted sum of the samples. The pulse phase (time) is a second weighted sum divided by that energy. A goodness-of-fit figure compares each sample against a stored reference pulse shape, scaled by the recovered energy and raised by a pedestal. Channels arrive one after another as groups of `NSAMP` unsigned samples. Every channel uses the same small coefficient table: amplitude weights, phase weights, shape values and a pedestal. Weights and shape values are signed Q1.14 numbers.

The engine is a single state machine that handles one channel at a time. State `ST_COLLECT` accepts samples and builds both weighted sums. When the last sample is taken it moves to `ST_SETUP`, which forms the energy. If the energy is zero it goes straight to `ST_FIT`. Otherwise it starts the divider and enters `ST_DIVIDE`. When the divider reports done, `ST_DIVIDE` moves to `ST_FIT`. `ST_FIT` makes a second pass over the stored samples and accumulates the squared residuals. After the last sample it moves to `ST_EMIT`, which presents the result for one cycle and then returns to `ST_COLLECT`. A register-write port loads the coefficient table.

Top module: `of_engine`

## Requirements
- R1: After reset, `s_ready` is 1, `res_valid` is 0, and `res_energy`, `res_time`, `res_quality` and `res_ezero` are all 0.
- R2: A sample is taken on each clock edge where `s_valid` and `s_ready` are both 1. The first sample taken for a channel is paired with coefficient index 0. After the `NSAMP`-th sample, `s_ready` is 0 until the result has been emitted. `s_valid` while `s_ready` is 0 has no effect on any result.
- R3: `res_energy` = floor(sum of S_i·a_i / 2^14), a signed 32-bit value. S_i is the unsigned sample and a_i the signed amplitude weight.
- R4: When the energy is non-zero, `res_time` = (sum of S_i·b_i) / energy, with the quotient truncated toward zero (signed, in units of 2^-14).
- R5: When the energy is zero, `res_time` is 0 and `res_ezero` is 1. Otherwise `res_ezero` is 0.
- R6: `res_quality` is the sum over i of sat16(S_i − (floor(sat16(E)·g_i / 2^14) + P))². E is the energy, g_i the shape value and P the pedestal. sat16 clamps to [−32768, 32767]. The sum saturates at 2^32−1.
- R7: The table write map is: addresses 0..6 hold a_0..a_6, addresses 8..14 hold b_0..b_6, addresses 16..22 hold g_0..g_6, and address 24 holds the pedestal. For the pedestal only the low 10 bits of the write data are kept.
- R8: Each channel yields exactly one result, in input order. `res_valid` is high for a single cycle, and `s_ready` is 1 in the cycle that follows.
- R9: `res_energy`, `res_time` and `res_quality` change only at the edge that raises `res_valid`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample valid |
| s_data | input | SW | Unsigned sample |
| s_ready | output | 1 | Engine accepts a sample |
| cfg_we | input | 1 | Table write enable |
| cfg_addr | input | IW+2 | Table write address |
| cfg_wdata | input | WW | Table write data |
| res_valid | output | 1 | Result strobe |
| res_energy | output | AW | Energy, signed |
| res_time | output | AW | Time, signed, 2^-14 units |
| res_quality | output | AW | Fit quality, unsigned, saturating |
| res_ezero | output | 1 | Energy was zero, time forced to 0 |

## Verification
The bench builds the engine with its default parameters: 7 samples of 10 bits, 16-bit coefficients, 32-bit accumulators and 14 fraction bits. With these widths a full-scale burst against full-scale weights and shape values drives the squared-residual sum past 2^32, so the quality clamp can be reached. The same settings also reach zero energy from a small non-zero weighted sum, and a negative energy that exercises the sign handling of the divider. Bursts that pause mid-channel, and input that keeps arriving while the divider runs, test the intake rules.

// File: rtl/of_pkg.sv
package of_pkg;
    typedef enum logic [2:0] {
        ST_COLLECT,
        ST_SETUP,
        ST_DIVIDE,
        ST_FIT,
        ST_EMIT
    } of_state_t;
endpackage

// File: rtl/of_coef_table.sv
module of_coef_table #(
    parameter int NSAMP = 7,
    parameter int SW    = 10,
    parameter int WW    = 16,
    parameter int IW    = 3
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          we,
    input  logic [IW+1:0]                 addr,
    input  logic [WW-1:0]                 wdata,
    output logic [NSAMP-1:0][WW-1:0]      wa,
    output logic [NSAMP-1:0][WW-1:0]      wb,
    output logic [NSAMP-1:0][WW-1:0]      wg,
    output logic [SW-1:0]                 ped
);
    logic [1:0]    bank;
    logic [IW-1:0] slot;

    assign bank = addr[IW+1:IW];
    assign slot = addr[IW-1:0];

    for (genvar i = 0; i < NSAMP; i++) begin : g_slot
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                wa[i] <= '0;
                wb[i] <= '0;
                wg[i] <= '0;
            end else if (we && slot == IW'(i)) begin
                if (bank == 2'd0) wa[i] <= wdata;
                if (bank == 2'd1) wb[i] <= wdata;
                if (bank == 2'd2) wg[i] <= wdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            ped <= '0;
        else if (we && bank == 2'd3 && slot == '0)
            ped <= wdata[SW-1:0];
    end
endmodule

// File: rtl/of_sdiv.sv
module of_sdiv #(
    parameter int W = 32
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                start,
    input  logic signed [W-1:0] num,
    input  logic signed [W-1:0] den,
    output logic                done,
    output logic signed [W-1:0] quo
);
    localparam int CW = $clog2(W + 1);

    logic [W-1:0]  n_r;
    logic [W-1:0]  d_r;
    logic [W:0]    rem;
    logic [W:0]    trial;
    logic          neg;
    logic [CW-1:0] cnt;

    assign trial = {rem[W-1:0], n_r[W-1]} - {1'b0, d_r};
    assign quo   = neg ? -$signed(n_r) : $signed(n_r);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            n_r  <= '0;
            d_r  <= '0;
            rem  <= '0;
            neg  <= 1'b0;
            cnt  <= '0;
            done <= 1'b0;
        end else begin
            done <= 1'b0;
            if (start) begin
                n_r <= num[W-1] ? W'(-num) : num;
                d_r <= den[W-1] ? W'(-den) : den;
                neg <= num[W-1] ^ den[W-1];
                rem <= '0;
                cnt <= CW'(W);
            end else if (cnt != '0) begin
                if (!trial[W]) begin
                    rem <= trial;
                    n_r <= {n_r[W-2:0], 1'b1};
                end else begin
                    rem <= {rem[W-1:0], n_r[W-1]};
                    n_r <= {n_r[W-2:0], 1'b0};
                end
                cnt  <= cnt - CW'(1);
                done <= (cnt == CW'(1));
            end
        end
    end
endmodule

// File: rtl/of_engine.sv
module of_engine
    import of_pkg::*;
#(
    parameter int  NSAMP = 7,
    parameter int  SW    = 10,
    parameter int  WW    = 16,
    parameter int  AW    = 32,
    parameter int  QF    = 14,
    localparam int IW    = $clog2(NSAMP)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 s_valid,
    input  logic [SW-1:0]        s_data,
    output logic                 s_ready,
    input  logic                 cfg_we,
    input  logic [IW+1:0]        cfg_addr,
    input  logic [WW-1:0]        cfg_wdata,
    output logic                 res_valid,
    output logic signed [AW-1:0] res_energy,
    output logic signed [AW-1:0] res_time,
    output logic [AW-1:0]        res_quality,
    output logic                 res_ezero
);
    localparam logic [IW-1:0]        LAST = IW'(NSAMP - 1);
    localparam logic signed [AW-1:0] SMAX = AW'((2 ** (WW - 1)) - 1);
    localparam logic signed [AW-1:0] SMIN = ~SMAX;

    function automatic logic signed [WW-1:0] sat_w(input logic signed [AW-1:0] v);
        if (v > SMAX)      return SMAX[WW-1:0];
        else if (v < SMIN) return SMIN[WW-1:0];
        else               return v[WW-1:0];
    endfunction

    of_state_t state, state_nx;

    logic [NSAMP-1:0][WW-1:0] wa, wb, wg;
    logic [SW-1:0]            ped;
    logic [NSAMP-1:0][SW-1:0] smp;
    logic [IW-1:0]            idx;
    logic signed [AW-1:0]     esum, tsum, energy_r, time_r, e_shift;
    logic [AW-1:0]            qacc;
    logic                     ezero_r;
    logic                     div_start, div_done;
    logic signed [AW-1:0]     div_q;

    of_coef_table #(.NSAMP(NSAMP), .SW(SW), .WW(WW), .IW(IW)) u_tab (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .addr(cfg_addr), .wdata(cfg_wdata),
        .wa(wa), .wb(wb), .wg(wg), .ped(ped)
    );

    assign e_shift = esum >>> QF;

    of_sdiv #(.W(AW)) u_div (
        .clk(clk), .rst_n(rst_n), .start(div_start),
        .num(tsum), .den(e_shift), .done(div_done), .quo(div_q)
    );

    // Intake products: sample as non-negative signed operand times weight
    logic signed [AW-1:0] x_in, pa, pb;
    assign x_in = AW'($signed({1'b0, s_data}));
    assign pa   = x_in * AW'($signed(wa[idx]));
    assign pb   = x_in * AW'($signed(wb[idx]));

    // Fit pass: residual against scaled shape plus pedestal
    logic signed [AW-1:0] pred, resid, sq;
    logic signed [WW-1:0] r_w;
    logic [AW:0]          qsum;
    logic [AW-1:0]        qnext;
    assign pred  = ((AW'(sat_w(energy_r)) * AW'($signed(wg[idx]))) >>> QF)
                 + AW'($signed({1'b0, ped}));
    assign resid = AW'($signed({1'b0, smp[idx]})) - pred;
    assign r_w   = sat_w(resid);
    assign sq    = AW'(r_w) * AW'(r_w);
    assign qsum  = {1'b0, qacc} + {1'b0, sq};
    assign qnext = qsum[AW] ? '1 : qsum[AW-1:0];

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_COLLECT;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_COLLECT: if (s_valid && idx == LAST) state_nx = ST_SETUP;
            ST_SETUP:   state_nx = (e_shift == '0) ? ST_FIT : ST_DIVIDE;
            ST_DIVIDE:  if (div_done) state_nx = ST_FIT;
            ST_FIT:     if (idx == LAST) state_nx = ST_EMIT;
            ST_EMIT:    state_nx = ST_COLLECT;
            default:    state_nx = ST_COLLECT;
        endcase
    end

    // Outputs decoded from the state
    always_comb begin
        s_ready   = (state == ST_COLLECT);
        res_valid = (state == ST_EMIT);
        div_start = (state == ST_SETUP) && (e_shift != '0);
    end

    // Datapath
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            smp         <= '0;
            idx         <= '0;
            esum        <= '0;
            tsum        <= '0;
            energy_r    <= '0;
            time_r      <= '0;
            qacc        <= '0;
            ezero_r     <= 1'b0;
            res_energy  <= '0;
            res_time    <= '0;
            res_quality <= '0;
            res_ezero   <= 1'b0;
        end else begin
            unique case (state)
                ST_COLLECT: if (s_valid) begin
                    smp[idx] <= s_data;
                    esum     <= esum + pa;
                    tsum     <= tsum + pb;
                    idx      <= (idx == LAST) ? '0 : idx + IW'(1);
                end
                ST_SETUP: begin
                    energy_r <= e_shift;
                    ezero_r  <= (e_shift == '0);
                    qacc     <= '0;
                    if (e_shift == '0) time_r <= '0;
                end
                ST_DIVIDE: if (div_done) time_r <= div_q;
                ST_FIT: begin
                    qacc <= qnext;
                    idx  <= (idx == LAST) ? '0 : idx + IW'(1);
                    if (idx == LAST) begin
                        res_energy  <= energy_r;
                        res_time    <= time_r;
                        res_quality <= qnext;
                        res_ezero   <= ezero_r;
                    end
                end
                ST_EMIT: begin
                    esum <= '0;
                    tsum <= '0;
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/of_engine_chk.sv
module of_engine_chk #(
    parameter int AW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          s_ready,
    input logic          res_valid,
    input logic          res_ezero,
    input logic [AW-1:0] res_energy,
    input logic [AW-1:0] res_time,
    input logic [AW-1:0] res_quality
);
    AST_STROBE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid);                                  // R8
    AST_READY_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> s_ready);                                     // R8
    AST_NO_INTAKE_AT_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> !s_ready);                                    // R2
    AST_ZERO_FLAG_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> (res_ezero == (res_energy == '0)));           // R5
    AST_ZERO_TIME: assert property (@(posedge clk) disable iff (!rst_n)
        (res_valid && res_ezero) |-> (res_time == '0));             // R5
    AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !res_valid |-> ($stable(res_energy) && $stable(res_time) && $stable(res_quality))); // R9
endmodule

bind of_engine of_engine_chk #(.AW(AW)) u_chk (
    .clk(clk), .rst_n(rst_n), .s_ready(s_ready), .res_valid(res_valid),
    .res_ezero(res_ezero), .res_energy(res_energy), .res_time(res_time),
    .res_quality(res_quality)
);

// File: tb/sim_of_engine.sv
module sim_of_engine;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        s_valid = 1'b0;
    logic [9:0]  s_data = '0;
    logic        s_ready;
    logic        cfg_we = 1'b0;
    logic [4:0]  cfg_addr = '0;
    logic [15:0] cfg_wdata = '0;
    logic        res_valid;
    logic signed [31:0] res_energy, res_time;
    logic [31:0] res_quality;
    logic        res_ezero;

    int total = 0;
    int bad = 0;

    always #10 clk = ~clk;

    of_engine u0 (
        .clk(clk), .rst_n(rst_n), .s_valid(s_valid), .s_data(s_data), .s_ready(s_ready),
        .cfg_we(cfg_we), .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata),
        .res_valid(res_valid), .res_energy(res_energy), .res_time(res_time),
        .res_quality(res_quality), .res_ezero(res_ezero)
    );

    int ca [7] = '{-1200, 1800, 5200, 7400, 5200, 1800, -1200};
    int cb [7] = '{-3000, -2000, -1000, 0, 1000, 2000, 3000};
    int cg [7] = '{0, 2400, 9000, 16384, 9000, 2400, 0};
    int ped_raw = 40;

    // stimulus rows: 7 samples, then gap flag (pause before sample 3)
    localparam int NV = 7;
    localparam int STIM [NV][8] = '{
        '{40, 40, 40, 40, 40, 40, 40, 0},
        '{40, 120, 400, 900, 400, 120, 40, 1},
        '{40, 80, 300, 700, 800, 300, 60, 0},
        '{1023, 1023, 1023, 1023, 1023, 1023, 1023, 1},
        '{900, 100, 0, 0, 0, 100, 700, 0},
        '{0, 0, 0, 0, 0, 0, 0, 0},
        '{0, 0, 0, 1, 0, 0, 0, 0}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint clamp16(input longint v);
        if (v > 32767) return 32767;
        if (v < -32768) return -32768;
        return v;
    endfunction

    function automatic void model(input int sv[7], output longint e, output longint t,
                                  output longint q, output bit z);
        longint es, ts, e16, p, r, pd;
        es = 0; ts = 0; q = 0;
        pd = longint'(ped_raw & 10'h3FF);
        for (int k = 0; k < 7; k++) begin
            es += longint'(sv[k]) * ca[k];
            ts += longint'(sv[k]) * cb[k];
        end
        e = es >>> 14;
        z = (e == 0);
        t = z ? 0 : ts / e;
        e16 = clamp16(e);
        for (int k = 0; k < 7; k++) begin
            p = ((e16 * cg[k]) >>> 14) + pd;
            r = clamp16(longint'(sv[k]) - p);
            q += r * r;
            if (q > 64'd4294967295) q = 64'd4294967295;
        end
    endfunction

    task automatic cfg_wr(input int a, input int d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_addr = 5'(a); cfg_wdata = 16'(d);
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic load_table();
        for (int i = 0; i < 7; i++) begin
            cfg_wr(i, ca[i]);
            cfg_wr(8 + i, cb[i]);
            cfg_wr(16 + i, cg[i]);
        end
        cfg_wr(24, ped_raw);
    endtask

    // send one channel, wait for its result and check it
    task automatic run_channel(input int sv[7], input bit gap, input bit jam, input string tag);
        longint e, t, q;
        bit z;
        int wd;
        model(sv, e, t, q, z);
        wd = 0;
        while (!s_ready && wd < 500) begin @(negedge clk); wd++; end
        for (int k = 0; k < 7; k++) begin
            if (gap && k == 3) begin s_valid = 1'b0; @(negedge clk); end
            s_valid = 1'b1; s_data = 10'(sv[k]); @(negedge clk);
        end
        s_valid = 1'b0;
        chk(s_ready == 1'b0, {"R2 ready low after last sample ", tag}, s_ready, 0);
        wd = 0;
        while (!res_valid && wd < 200) begin
            if (jam) begin s_valid = 1'b1; s_data = 10'd777; end
            @(negedge clk); wd++;
        end
        s_valid = 1'b0;
        chk(res_valid == 1'b1, {"R8 result strobe ", tag}, res_valid, 1);
        chk(longint'(res_energy) == e, {"R3 energy ", tag}, res_energy, e);
        chk(longint'(res_time) == t, {"R4 time ", tag}, res_time, t);
        chk(res_ezero == z, {"R5 zero flag ", tag}, res_ezero, z);
        chk(longint'(res_quality) == q, {"R6 quality ", tag}, res_quality, q);
        @(negedge clk);
        chk(res_valid == 1'b0 && s_ready == 1'b1, {"R8 single strobe then ready ", tag},
            {res_valid, s_ready}, 1);
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        bad++; total++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin : main
        int row[7];
        logic signed [31:0] he, ht;
        logic [31:0] hq;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(s_ready == 1'b1, "R1 s_ready", s_ready, 1);
        chk(res_valid == 1'b0, "R1 res_valid", res_valid, 0);
        chk(res_energy == 0 && res_time == 0 && res_quality == 0 && res_ezero == 0,
            "R1 outputs zero", res_quality, 0);
        rst_n = 1'b1;
        @(negedge clk);
        // R7 table map; pedestal keeps low 10 bits only
        ped_raw = 16'hFC28;
        load_table();

        // table walk: R3 R4 R5 R6 R8, gap rows exercise R2
        for (int v = 0; v < NV; v++) begin
            for (int k = 0; k < 7; k++) row[k] = STIM[v][k];
            run_channel(row, STIM[v][7] != 0, 1'b0, $sformatf("row%0d", v));
        end

        // R2: input while busy is ignored; next channel still exact
        for (int k = 0; k < 7; k++) row[k] = STIM[1][k];
        run_channel(row, 1'b0, 1'b1, "R2 jam during processing");
        for (int k = 0; k < 7; k++) row[k] = STIM[2][k];
        run_channel(row, 1'b0, 1'b0, "R2 channel after jam");

        // R9: outputs hold while idle
        he = res_energy; ht = res_time; hq = res_quality;
        repeat (20) @(negedge clk);
        chk(res_energy == he && res_time == ht && res_quality == hq,
            "R9 results held", res_quality, hq);

        // R6 saturation, with R7 reprogrammed table
        for (int i = 0; i < 7; i++) begin ca[i] = 32767; cg[i] = 32767; end
        load_table();
        for (int k = 0; k < 7; k++) row[k] = 1023;
        run_channel(row, 1'b0, 1'b0, "R6 saturated quality");
        chk(res_quality == 32'hFFFF_FFFF, "R6 clamp value", res_quality, 32'hFFFF_FFFF);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule